// File: doc/BRIEF.md
# Vector Element-Loop Issue Sequencer

This block sits in the issue stage and expands one scalar-form add into a series of element adds over consecutive registers. A status register holds a vector length and a current element step. When an add is accepted, the sequencer walks the step from its current value up to the vector length minus one. For each element it offsets the destination and both source register numbers by the step, reads the operands, adds them and writes the sum back. The walk is done one element at a time by a counter in a state machine, never by unrolled hardware.

Every element takes three cycles: operand read, add, write back. The register file has 32 entries of 64 bits, with registered reads of one-cycle latency. Elements are handled strictly in order, so a later element reads a value written by an earlier one when the register ranges overlap. A set-length operation loads the length and clears the step. Software can read the status register at any time and can load it while the sequencer is idle. A host port loads and reads the register file while no loop runs.

Top module: `vec_elem_seq`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `stat_rdata` is 0.
- R2: While idle, `setvl_valid` loads `setvl_len` into the length field `stat_rdata[5:0]` and clears the step field `stat_rdata[11:6]`.
- R3: While idle, `stat_we` (without `setvl_valid` or `issue_valid`) loads `stat_wdata` whole: step in bits [11:6], length in bits [5:0]. `stat_rdata` always shows the current value.
- R4: While `busy` is high, `stat_we` and `setvl_valid` have no effect. The length field never changes during a run.
- R5: An accepted add with step s and length L performs, for i = s, s+1, ..., L-1 in that order, reg[rt+i] = reg[ra+i] + reg[rb+i] modulo 2^64. Each element sees the writes of earlier elements.
- R6: Register numbers rt+i, ra+i and rb+i wrap modulo 32.
- R7: Each element takes 3 cycles. `done` is high in the cycle that follows the 3n+1-th rising edge after acceptance, where n is the number of elements run. The step field stays the same or rises by one per cycle during a run, or returns to 0.
- R8: `done` is a single-cycle pulse while `busy` is still high. At `done` the step field reads 0. `busy` is low in the next cycle.
- R9: `issue_valid` while idle starts a run, and `busy` rises on the next cycle. `issue_valid` while busy is ignored.
- R10: If the step is not below the length (including length 0), an accepted add writes no register and raises `done` after one cycle.
- R11: While idle, `host_we` writes `host_wdata` to `host_waddr`. While busy, `host_we` is ignored. `host_rdata` returns the entry at `host_raddr` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Add instruction present |
| issue_rt | input | 5 | Destination base register |
| issue_ra | input | 5 | First source base register |
| issue_rb | input | 5 | Second source base register |
| setvl_valid | input | 1 | Set-length request |
| setvl_len | input | 6 | New vector length |
| stat_we | input | 1 | Status register write |
| stat_wdata | input | 12 | Status write data {step, length} |
| stat_rdata | output | 12 | Status register {step, length} |
| host_we | input | 1 | Host register-file write |
| host_waddr | input | 5 | Host write address |
| host_wdata | input | 64 | Host write data |
| host_raddr | input | 5 | Host read address |
| host_rdata | output | 64 | Host read data, one cycle latency |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A step counter that skips or stalls, or a wrong wrap of a register number, leaves a wrong value in a specific register. That value shows on the host read port right after `done`. An extra or missing element cycle moves the `done` pulse away from the 3n+1 edge count, so it is seen within the same instruction. A status field disturbed during a run shows on `stat_rdata` in the very next cycle. Overlapping register ranges and runs that start at a nonzero step expose an ordering fault as a wrong sum after the run.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    localparam int REG_AW = 5;
    localparam int VL_W   = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_EXEC,
        ST_WRITE,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [VL_W-1:0] step;
        logic [VL_W-1:0] vl;
    } vstat_t;

    typedef struct packed {
        logic [REG_AW-1:0] rt;
        logic [REG_AW-1:0] ra;
        logic [REG_AW-1:0] rb;
    } add_instr_t;

    // Element register number: base plus step, wrapping over the file.
    function automatic logic [REG_AW-1:0] elem_addr(logic [REG_AW-1:0] base,
                                                    logic [VL_W-1:0]   step);
        return base + step[REG_AW-1:0];
    endfunction

    function automatic logic last_elem(vstat_t s);
        return ({1'b0, s.step} + 1'b1) == {1'b0, s.vl};
    endfunction

    function automatic logic run_empty(vstat_t s);
        return s.step >= s.vl;
    endfunction

endpackage

// File: rtl/vseq_regfile.sv
module vseq_regfile #(
    parameter int XLEN = 64,
    parameter int AW   = 5
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   a_addr,
    input  logic [AW-1:0]   b_addr,
    input  logic [AW-1:0]   h_addr,
    output logic [XLEN-1:0] a_data,
    output logic [XLEN-1:0] b_data,
    output logic [XLEN-1:0] h_data
);
    localparam int DEPTH = 1 << AW;

    logic [XLEN-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        a_data <= mem[a_addr];
        b_data <= mem[b_addr];
        h_data <= mem[h_addr];
    end

endmodule

// File: rtl/vseq_status.sv
module vseq_status
    import vseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            upd_en,
    input  logic            setvl_v,
    input  logic [VL_W-1:0] setvl_len,
    input  logic            sw_we,
    input  vstat_t          sw_data,
    input  logic            step_clr,
    input  logic            step_inc,
    output vstat_t          stat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else if (step_clr) begin
            stat.step <= '0;
        end else if (step_inc) begin
            stat.step <= stat.step + 1'b1;
        end else if (upd_en) begin
            if (setvl_v) begin
                stat.vl   <= setvl_len;
                stat.step <= '0;
            end else if (sw_we) begin
                stat <= sw_data;
            end
        end
    end

endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
    import vseq_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  add_instr_t        issue,
    input  vstat_t            stat,
    input  logic [XLEN-1:0]   op_a,
    input  logic [XLEN-1:0]   op_b,
    output logic              accept,
    output logic              busy,
    output logic              done,
    output logic              step_inc,
    output logic              step_clr,
    output logic [REG_AW-1:0] rd_a_addr,
    output logic [REG_AW-1:0] rd_b_addr,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [XLEN-1:0]   wr_data
);
    seq_state_e      state;
    add_instr_t      instr_q;
    logic [XLEN-1:0] sum_q;

    assign accept    = (state == ST_IDLE) && issue_valid;
    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_DONE);
    assign wr_en     = (state == ST_WRITE);
    assign wr_addr   = elem_addr(instr_q.rt, stat.step);
    assign wr_data   = sum_q;
    assign rd_a_addr = elem_addr(instr_q.ra, stat.step);
    assign rd_b_addr = elem_addr(instr_q.rb, stat.step);

    always_comb begin
        step_inc = 1'b0;
        step_clr = 1'b0;
        if (accept && run_empty(stat)) begin
            step_clr = 1'b1;
        end else if (state == ST_WRITE) begin
            if (last_elem(stat)) step_clr = 1'b1;
            else                 step_inc = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            instr_q <= '0;
            sum_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (issue_valid) begin
                        instr_q <= issue;
                        state   <= run_empty(stat) ? ST_DONE : ST_READ;
                    end
                end
                ST_READ:  state <= ST_EXEC;
                ST_EXEC: begin
                    sum_q <= op_a + op_b;
                    state <= ST_WRITE;
                end
                ST_WRITE: state <= last_elem(stat) ? ST_DONE : ST_READ;
                ST_DONE:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
    import vseq_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic [REG_AW-1:0] issue_rt,
    input  logic [REG_AW-1:0] issue_ra,
    input  logic [REG_AW-1:0] issue_rb,
    input  logic              setvl_valid,
    input  logic [VL_W-1:0]   setvl_len,
    input  logic              stat_we,
    input  logic [2*VL_W-1:0] stat_wdata,
    output logic [2*VL_W-1:0] stat_rdata,
    input  logic              host_we,
    input  logic [REG_AW-1:0] host_waddr,
    input  logic [XLEN-1:0]   host_wdata,
    input  logic [REG_AW-1:0] host_raddr,
    output logic [XLEN-1:0]   host_rdata,
    output logic              busy,
    output logic              done
);
    vstat_t            stat;
    add_instr_t        instr;
    logic              accept, step_inc, step_clr;
    logic [REG_AW-1:0] rd_a_addr, rd_b_addr, seq_waddr, rf_waddr;
    logic              seq_we, rf_we;
    logic [XLEN-1:0]   seq_wdata, rf_wdata, op_a, op_b;

    assign instr      = '{rt: issue_rt, ra: issue_ra, rb: issue_rb};
    assign stat_rdata = stat;

    // Sequencer write has the port while running; host only when idle.
    assign rf_we    = seq_we || (host_we && !busy);
    assign rf_waddr = seq_we ? seq_waddr : host_waddr;
    assign rf_wdata = seq_we ? seq_wdata : host_wdata;

    vseq_ctrl #(.XLEN(XLEN)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .issue_valid(issue_valid),
        .issue      (instr),
        .stat       (stat),
        .op_a       (op_a),
        .op_b       (op_b),
        .accept     (accept),
        .busy       (busy),
        .done       (done),
        .step_inc   (step_inc),
        .step_clr   (step_clr),
        .rd_a_addr  (rd_a_addr),
        .rd_b_addr  (rd_b_addr),
        .wr_en      (seq_we),
        .wr_addr    (seq_waddr),
        .wr_data    (seq_wdata)
    );

    vseq_status u_status (
        .clk      (clk),
        .rst      (rst),
        .upd_en   (!busy && !accept),
        .setvl_v  (setvl_valid),
        .setvl_len(setvl_len),
        .sw_we    (stat_we),
        .sw_data  (vstat_t'(stat_wdata)),
        .step_clr (step_clr),
        .step_inc (step_inc),
        .stat     (stat)
    );

    vseq_regfile #(.XLEN(XLEN), .AW(REG_AW)) u_rf (
        .clk   (clk),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .a_addr(rd_a_addr),
        .b_addr(rd_b_addr),
        .h_addr(host_raddr),
        .a_data(op_a),
        .b_data(op_b),
        .h_data(host_rdata)
    );

endmodule

// File: rtl/vec_elem_seq_chk.sv
module vec_elem_seq_chk
    import vseq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              issue_valid,
    input logic              busy,
    input logic              done,
    input logic [2*VL_W-1:0] stat_rdata
);
    logic [VL_W-1:0] stp;
    logic [VL_W-1:0] len;
    assign stp = stat_rdata[2*VL_W-1:VL_W];
    assign len = stat_rdata[VL_W-1:0];

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    assert_done_step_zero_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (stp == '0));

    assert_len_hold_R4: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(len));

    assert_accept_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && issue_valid) |=> busy);

    assert_step_advance_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> (stp == $past(stp) || stp == $past(stp) + 1'b1 || stp == '0));

endmodule

bind vec_elem_seq vec_elem_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .issue_valid(issue_valid),
    .busy       (busy),
    .done       (done),
    .stat_rdata (stat_rdata)
);

// File: tb/tb_vec_elem_seq.sv
module tb_vec_elem_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [4:0]  issue_rt = '0, issue_ra = '0, issue_rb = '0;
    logic        setvl_valid = 1'b0;
    logic [5:0]  setvl_len = '0;
    logic        stat_we = 1'b0;
    logic [11:0] stat_wdata = '0;
    logic [11:0] stat_rdata;
    logic        host_we = 1'b0;
    logic [4:0]  host_waddr = '0, host_raddr = '0;
    logic [63:0] host_wdata = '0, host_rdata;
    logic        busy, done;

    int n_chk = 0;
    int n_err = 0;
    logic [63:0] ref_rf [32];
    int ref_vl = 0;
    int ref_step = 0;

    always #5 clk = ~clk;

    vec_elem_seq dut (.*);

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    task automatic host_wr(logic [4:0] a, logic [63:0] d);
        @(negedge clk);
        host_we = 1'b1; host_waddr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_rd(logic [4:0] a, output logic [63:0] d);
        @(negedge clk);
        host_raddr = a;
        @(negedge clk);
        d = host_rdata;
    endtask

    task automatic load_all();
        for (int k = 0; k < 32; k++) begin
            logic [63:0] v;
            v = {$urandom, $urandom};
            ref_rf[k] = v;
            host_wr(k[4:0], v);
        end
    endtask

    task automatic check_all(string tag);
        for (int k = 0; k < 32; k++) begin
            logic [63:0] d;
            host_rd(k[4:0], d);
            chk(tag, d, ref_rf[k]);
        end
    endtask

    task automatic do_setvl(int len);
        @(negedge clk);
        setvl_valid = 1'b1; setvl_len = len[5:0];
        @(negedge clk);
        setvl_valid = 1'b0;
        ref_vl = len; ref_step = 0;
    endtask

    task automatic do_statw(int stp, int len);
        @(negedge clk);
        stat_we = 1'b1; stat_wdata = {stp[5:0], len[5:0]};
        @(negedge clk);
        stat_we = 1'b0;
        ref_vl = len; ref_step = stp;
    endtask

    // Sequential reference of the element loop.
    function automatic int model_add(int rt, int ra, int rb);
        int n;
        n = 0;
        for (int i = ref_step; i < ref_vl; i++) begin
            ref_rf[(rt + i) % 32] = ref_rf[(ra + i) % 32] + ref_rf[(rb + i) % 32];
            n++;
        end
        ref_step = 0;
        return n;
    endfunction

    task automatic run_add(int rt, int ra, int rb, string tag);
        int n, cyc;
        n = model_add(rt, ra, rb);
        @(negedge clk);
        issue_valid = 1'b1;
        issue_rt = rt[4:0]; issue_ra = ra[4:0]; issue_rb = rb[4:0];
        @(negedge clk);
        issue_valid = 1'b0;
        cyc = 1;
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        chk({tag, " R7 done latency"}, 64'(cyc), 64'(3 * n + 1));
        chk({tag, " R8 status at done"}, 64'(stat_rdata), 64'(ref_vl));
        chk({tag, " R8 busy at done"}, 64'(busy), 64'd1);
        @(negedge clk);
        chk({tag, " R8 done one cycle"}, 64'(done), 64'd0);
        chk({tag, " R8 busy after done"}, 64'(busy), 64'd0);
        check_all({tag, " R5 regs"});
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 status", 64'(stat_rdata), 64'd0);

        load_all();
        check_all("R11 host load");

        do_setvl(5);
        chk("R2 setvl", 64'(stat_rdata), 64'd5);
        run_add(10, 0, 5, "basic");

        do_setvl(1);
        run_add(3, 7, 7, "single");

        do_statw(2, 6);
        chk("R3 status write", 64'(stat_rdata), {52'd0, 6'd2, 6'd6});
        do_setvl(9);
        chk("R2 setvl clears step", 64'(stat_rdata), 64'd9);
        do_statw(2, 6);
        run_add(12, 14, 16, "R3 start at step");

        do_setvl(6);
        run_add(29, 30, 27, "R6 wrap");

        do_setvl(4);
        run_add(9, 8, 20, "R5 overlap");

        do_setvl(0);
        run_add(1, 2, 3, "R10 zero length");
        do_statw(4, 3);
        run_add(1, 2, 3, "R10 step past length");

        // Requests while busy: none may take effect.
        begin
            int ndone;
            int nel;
            do_setvl(3);
            nel = model_add(1, 2, 3);
            @(negedge clk);
            issue_valid = 1'b1; issue_rt = 5'd1; issue_ra = 5'd2; issue_rb = 5'd3;
            @(negedge clk);
            issue_valid = 1'b0;
            @(negedge clk);
            stat_we = 1'b1; stat_wdata = {6'd1, 6'd7};
            setvl_valid = 1'b1; setvl_len = 6'd11;
            issue_valid = 1'b1; issue_rt = 5'd25; issue_ra = 5'd0; issue_rb = 5'd0;
            host_we = 1'b1; host_waddr = 5'd20; host_wdata = 64'hdead_beef;
            @(negedge clk);
            stat_we = 1'b0; setvl_valid = 1'b0; issue_valid = 1'b0; host_we = 1'b0;
            chk("R4 length held while busy", 64'(stat_rdata[5:0]), 64'd3);
            ndone = 0;
            for (int c = 0; c < 3 * nel + 10; c++) begin
                if (done) ndone++;
                @(negedge clk);
            end
            chk("R9 single completion", 64'(ndone), 64'd1);
            chk("R4 status after run", 64'(stat_rdata), 64'd3);
            check_all("R9 R11 busy requests ignored");
        end

        for (int it = 0; it < 25; it++) begin
            int len, rt, ra, rb;
            len = int'($urandom % 12);
            rt = int'($urandom % 32); ra = int'($urandom % 32); rb = int'($urandom % 32);
            if ($urandom % 4 == 0) do_statw(int'($urandom % 8), len);
            else                   do_setvl(len);
            run_add(rt, ra, rb, "random R5 R6");
        end

        finish_run();
    end

endmodule